// File: doc/BRIEF.md
# Banked Misaligned Access Splitter

This block connects a processor-side request port to a memory made of eight byte-wide banks. The eight banks sit side by side and form one 64-bit row. A request carries a byte address, a size code (1, 2, 4 or 8 bytes), a read/write flag and write data.

The three low address bits choose the bank where the transfer starts, and the upper bits choose the row. When the transfer fits inside one row, the block issues one row transaction. When it runs past bank 7, the block splits it into two transactions: the second uses the next row and continues from bank 0. Write bytes are steered onto the right banks. Read bytes from one or two transactions are merged and returned right-justified.

The memory side uses active-low read and write strobes, one enable bit per bank, and returns read data one cycle after a strobe. The request side uses a valid/ready handshake and a one-cycle completion pulse.

Top module: `bank_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, both memory strobes are 1 and `done` is 0.
- R2: Size codes on `req_size` are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The first transaction enables bank bits from `req_addr[2:0]` upward, covering the transfer bytes that fit below bank 8. Bit k of `mem_be` is bank k.
- R3: An access with `req_addr[2:0]` + size ≤ 8 uses exactly one transaction, on row `req_addr >> 3`. An example is 4 bytes at 0x1234.
- R4: An access that runs past bank 7 uses exactly two transactions in consecutive cycles. The first is on row `req_addr >> 3`, the second on that row + 1, with banks enabled from 0 upward for the remaining bytes. Examples are 8 bytes at 0x1234 and at 0x0A6F257. No access ever takes more than two.
- R5: A write drives `mem_wr_n` low during its transactions. Request byte i (`req_wdata[8i+7:8i]`) goes to bank (`req_addr[2:0]` + i) mod 8, and only bytes below the size are stored. A completed write returns `rdata` = 0.
- R6: A read drives `mem_rd_n` low during its transactions. `rdata` byte i holds memory byte `req_addr` + i, and bytes at or above the size are 0.
- R7: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from then until completion. `done` is a single-cycle pulse, high in the cycle after the cycle that follows the last transaction, and `rdata` is valid with it.
- R8: The two memory strobes are never low together, and both are high outside transaction cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data, right-justified |
| done | output | 1 | Completion pulse |
| rdata | output | 64 | Read result, right-justified, zero-extended |
| mem_row | output | ADDR_W-3 | Row address |
| mem_be | output | 8 | Per-bank enable |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_wdata | output | 64 | Bank-steered write data |
| mem_rdata | input | 64 | Row read data, one cycle after the strobe |

## Verification
The bench builds the block with ADDR_W=28. This makes room for the 28-bit example address 0x0A6F257, so its split at a high row and its row increment are exercised directly. The memory model keeps 64 rows and aliases on the low nine address bits. This lets all 32 size and offset combinations, including every row-crossing case, be written and read back against a flat byte array of the same span.

// File: rtl/bank_splitter.sv
module bank_splitter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [63:0]       req_wdata,
  output logic              done,
  output logic [63:0]       rdata,
  output logic [ADDR_W-4:0] mem_row,
  output logic [7:0]        mem_be,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  localparam int ROW_W = ADDR_W - 3;

  typedef enum logic [1:0] {S_IDLE, S_B1, S_B2, S_WT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic [1:0]        sz_q;
  logic              wr_q;
  logic [63:0]       wd_q, acc_q, rdata_q;
  logic              done_q;

  function automatic logic [63:0] expand(input logic [7:0] m);
    for (int i = 0; i < 8; i++) expand[8*i +: 8] = {8{m[i]}};
  endfunction

  logic [2:0]   off;
  logic [7:0]   nmask, be1, be2;
  logic [15:0]  span;
  logic         split, beat;
  logic [127:0] wrot, rrot;
  logic [63:0]  merged;

  assign off = a_q[2:0];

  always_comb begin
    case (sz_q)
      2'd0:    nmask = 8'h01;
      2'd1:    nmask = 8'h03;
      2'd2:    nmask = 8'h0F;
      default: nmask = 8'hFF;
    endcase
  end

  assign span  = {8'h00, nmask} << off;
  assign be1   = span[7:0];
  assign be2   = span[15:8];
  assign split = |be2;
  assign beat  = (st == S_B1) || (st == S_B2);

  assign req_ready = (st == S_IDLE);
  assign mem_row   = a_q[ADDR_W-1:3] + ROW_W'(st == S_B2);
  assign mem_be    = beat ? ((st == S_B2) ? be2 : be1) : 8'h00;
  assign mem_rd_n  = !(beat && !wr_q);
  assign mem_wr_n  = !(beat && wr_q);

  assign wrot      = {wd_q, wd_q} << {off, 3'b000};
  assign mem_wdata = wrot[127:64];

  assign merged = acc_q | (mem_rdata & expand(split ? be2 : be1));
  assign rrot   = {merged, merged} >> {off, 3'b000};

  assign done  = done_q;
  assign rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      sz_q    <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          sz_q  <= req_size;
          wr_q  <= req_write;
          wd_q  <= req_wdata;
          acc_q <= '0;
          st    <= S_B1;
        end
        S_B1: st <= split ? S_B2 : S_WT;
        S_B2: begin
          acc_q <= mem_rdata & expand(be1);
          st    <= S_WT;
        end
        default: begin
          done_q  <= 1'b1;
          rdata_q <= wr_q ? 64'd0 : (rrot[63:0] & expand(nmask));
          st      <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module bank_splitter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-4:0] mem_row,
  input logic [7:0]        mem_be,
  input logic              mem_rd_n,
  input logic              mem_wr_n
);
  logic act;
  assign act = !mem_rd_n || !mem_wr_n;

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !req_ready);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_two_beats_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |=> !act);

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> (mem_row == $past(mem_row) + 1'b1));

  p_be_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (mem_be != 8'h00));
endmodule

bind bank_splitter bank_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .mem_row(mem_row), .mem_be(mem_be), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
);

// File: tb/bank_splitter_tb.sv
module bank_splitter_tb;
  localparam int AW = 28;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [63:0]   req_wdata = '0;
  logic          req_ready, done, mem_rd_n, mem_wr_n;
  logic [63:0]   rdata, mem_wdata, mem_rdata;
  logic [AW-4:0] mem_row;
  logic [7:0]    mem_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_splitter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_row(mem_row),
    .mem_be(mem_be), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0]  bank [64][8];
  logic [7:0]  refm [512];
  logic [63:0] mrd = '0;
  assign mem_rdata = mrd;

  always @(posedge clk) begin
    for (int l = 0; l < 8; l++)
      if (!mem_wr_n && mem_be[l]) bank[mem_row[5:0]][l] <= mem_wdata[8*l +: 8];
    if (!mem_rd_n)
      for (int l = 0; l < 8; l++) mrd[8*l +: 8] <= bank[mem_row[5:0]][l];
  end

  typedef struct {
    int            beats;
    logic [AW-4:0] row0;
    logic [7:0]    be0;
    logic [63:0]   data;
    string         tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input int sz, input bit wr, input logic [63:0] wd);
    exp_t e;
    int n = 1 << sz;
    int o = int'(a[2:0]);
    e.beats = (o + n > 8) ? 2 : 1;
    e.row0  = a[AW-1:3];
    e.be0   = '0;
    for (int i = 0; i < n; i++) if (o + i < 8) e.be0[o+i] = 1'b1;
    e.data  = '0;
    for (int i = 0; i < n; i++) begin
      logic [8:0] idx = a[8:0] + 9'(i);
      if (wr) refm[idx] = wd[8*i +: 8];
      else    e.data[8*i +: 8] = refm[idx];
    end
    e.tag = wr ? "R5" : "R6";
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  int beat_cnt = 0;
  logic [AW-4:0] seen_row;
  logic [7:0]    seen_be;

  always @(negedge clk) if (rst_n && !finished) begin
    if (done) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R7 unexpected done", 64'd1, 64'd0);
      else begin
        e = q.pop_front();
        chk(beat_cnt == e.beats, (e.beats == 2) ? "R4 beat count" : "R3 beat count",
            64'(beat_cnt), 64'(e.beats));
        chk(seen_row == e.row0, "R3 first row", 64'(seen_row), 64'(e.row0));
        chk(seen_be == e.be0, "R2 first bank enables", 64'(seen_be), 64'(e.be0));
        chk(rdata == e.data, e.tag, rdata, e.data);
      end
      beat_cnt = 0;
    end
    if (!mem_rd_n || !mem_wr_n) begin
      chk(!req_ready, "R7 ready during transaction", 64'(req_ready), 64'd0);
      chk(mem_rd_n || mem_wr_n, "R8 both strobes", {mem_rd_n, mem_wr_n}, 64'd1);
      beat_cnt++;
      if (beat_cnt == 1) begin seen_row = mem_row; seen_be = mem_be; end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) refm[i] = 8'(i * 7 + 3);
    for (int r = 0; r < 64; r++)
      for (int l = 0; l < 8; l++) bank[r][l] = refm[r*8 + l];
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(mem_rd_n && mem_wr_n, "R1 strobes in reset", {mem_rd_n, mem_wr_n}, 64'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    chk(req_ready && mem_rd_n && mem_wr_n, "R1 idle after reset",
        {req_ready, mem_rd_n, mem_wr_n}, 64'd7);

    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        do_req(AW'(32'h200 + s*32'h40 + o), s, 1'b1,
               64'h0123_4567_89AB_CDEF ^ {8{8'(s*16 + o)}});
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        do_req(AW'(32'h200 + s*32'h40 + o), s, 1'b0, '0);

    do_req(AW'(32'h1234), 3, 1'b1, 64'hFEDC_BA98_7654_3210);
    do_req(AW'(32'h1234), 2, 1'b0, '0);
    do_req(AW'(32'h1234), 3, 1'b0, '0);
    do_req(AW'(32'h0A6F257), 3, 1'b0, '0);
    do_req(AW'(32'h0A6F257), 3, 1'b1, 64'h1122_3344_5566_7788);
    do_req(AW'(32'h0A6F257), 1, 1'b0, '0);
    do_req(AW'(32'h0A6F256), 3, 1'b0, '0);
    do_req(AW'(32'h1FF), 1, 1'b0, '0);
    do_req(AW'(32'h1F8), 3, 1'b0, '0);

    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule